// File: doc/BRIEF.md
# Butterfly Bit-Permutation Unit (reverse, OR-combine, zip, unzip)

This unit rearranges the bits of a 64-bit word with a butterfly network of six stages. Stage k works on bit blocks of 2^k bits and is switched on by bit k of a shift amount taken from the control operand. A 2-bit opcode selects one of four operations:
- generalized bit reverse, which swaps neighbouring blocks;
- generalized OR-combine, which ORs each block with its swapped neighbour;
- perfect shuffle (zip);
- unshuffle (unzip), which undoes the shuffle.

Uses include byte and nibble reversal, bit-order reversal, "any bit set in this byte" masks and interleaving of two halves of a word.

Operands enter on a valid/ready stream. The result leaves on a second valid/ready stream from a single output register.

Input stream rules:
- A transfer takes place on a rising clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high while the output register is empty, or while its content is being taken in the same cycle.

Output stream rules:
- The result of a transfer appears on the next edge.
- While `out_valid` is high and `out_ready` is low, the output holds its value and no new operand is taken.

Top module: `bperm_unit`

## Requirements
- R1: After reset `out_valid` is 0, `out_data` is 0 and `in_ready` is 1.
- R2: An accepted input (`in_valid` and `in_ready` high at a rising edge) makes `out_valid` high with its result after that same edge. Back-to-back transfers each give a result one cycle later. With no new transfer, a result taken with `out_ready` high leaves `out_valid` low.
- R3: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data` stays unchanged.
- R4: Opcode 00 (reverse) with amount a = `in_ctl[5:0]` gives result bit i = input bit (i XOR a). Amount 63 reverses the whole word.
- R5: Opcode 01 (OR-combine) gives result bit i = OR of input bits j over all j with (i XOR j) AND NOT a = 0. It never clears an input bit that is set.
- R6: Opcode 10 (shuffle) with amount s = `in_ctl[4:0]` runs the zip stages in the order 16, 8, 4, 2, 1, each only when its bit of s is set. A stage of distance N uses the mask pair (L, R): (0x0000ffff00000000, 0x00000000ffff0000) for 16, (0x00ff000000ff0000, 0x0000ff000000ff00) for 8, (0x0f000f000f000f00, 0x00f000f000f000f0) for 4, (0x3030303030303030, 0x0c0c0c0c0c0c0c0c) for 2 and (0x4444444444444444, 0x2222222222222222) for 1. It computes x = (x & ~(L|R)) | ((x<<N) & L) | ((x>>N) & R). With s = 31 the result has bit 2i = input bit i and bit 2i+1 = input bit i+32.
- R7: Opcode 11 (unshuffle) runs the same stages in the order 1, 2, 4, 8, 16. Unshuffling a shuffle result with the same amount returns the original word.
- R8: Control bits 63:6 have no effect on reverse and OR-combine, and control bits 63:5 have no effect on shuffle and unshuffle.
- R9: An amount of zero returns the input word unchanged for every opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| in_op | input | 2 | Operation: 00 reverse, 01 OR-combine, 10 shuffle, 11 unshuffle |
| in_data | input | 64 | Word to permute |
| in_ctl | input | 64 | Control word; low bits carry the shift amount |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_data | output | 64 | Permuted result |

## Verification
Every result is due exactly one clock edge after the edge that accepted its operands. The bench drives operands on the falling edge and reads `out_valid` and `out_data` at the following falling edge, with one rising edge in between. During back-pressure the bench reads each falling edge while `out_ready` is low and expects the held value. The new result is expected one edge after `out_ready` returns high. The checks on `in_ready` are made a moment after `out_ready` changes, because `in_ready` follows `out_ready` in the same cycle.

// File: rtl/bperm_pkg.sv
package bperm_pkg;

  typedef enum logic [1:0] {
    BP_REV    = 2'b00,
    BP_ORC    = 2'b01,
    BP_ZIP    = 2'b10,
    BP_UNZIP  = 2'b11
  } bp_op_e;

endpackage

// File: rtl/bperm_swap_net.sv
// Six-stage swap network shared by reverse and OR-combine.
module bperm_swap_net #(
  parameter int unsigned W  = 64,
  parameter int unsigned LW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [LW-1:0] amt,
  input  logic          merge,
  output logic [W-1:0]  dout
);

  function automatic logic [W-1:0] low_half_mask(int unsigned k);
    logic [W-1:0] m;
    for (int unsigned i = 0; i < W; i++) begin
      m[i] = (((i >> k) & 1) == 0);
    end
    return m;
  endfunction

  logic [W-1:0] stg [0:LW];
  assign stg[0] = din;

  for (genvar k = 0; k < LW; k++) begin : g_stage
    localparam logic [W-1:0] LO = low_half_mask(k);
    localparam int unsigned  D  = 1 << k;
    logic [W-1:0] swapped;
    assign swapped = ((stg[k] & LO) << D) | ((stg[k] & ~LO) >> D);
    always_comb begin
      if (!amt[k])    stg[k+1] = stg[k];
      else if (merge) stg[k+1] = stg[k] | swapped;
      else            stg[k+1] = swapped;
    end
  end

  assign dout = stg[LW];

endmodule

// File: rtl/bperm_zip_net.sv
// Five-stage zip network; stage order flips for the inverse operation.
module bperm_zip_net #(
  parameter int unsigned W  = 64,
  parameter int unsigned LW = $clog2(W),
  parameter int unsigned NS = LW - 1
) (
  input  logic [W-1:0]  din,
  input  logic [NS-1:0] amt,
  input  logic          unzip,
  output logic [W-1:0]  dout
);

  function automatic logic [W-1:0] upper_mask(int unsigned k);
    logic [W-1:0] m;
    for (int unsigned i = 0; i < W; i++) begin
      m[i] = (((i >> (k + 1)) & 1) == 1) && (((i >> k) & 1) == 0);
    end
    return m;
  endfunction

  function automatic logic [W-1:0] lower_mask(int unsigned k);
    logic [W-1:0] m;
    for (int unsigned i = 0; i < W; i++) begin
      m[i] = (((i >> (k + 1)) & 1) == 0) && (((i >> k) & 1) == 1);
    end
    return m;
  endfunction

  logic [W-1:0] stg [0:NS];
  assign stg[0] = din;

  for (genvar p = 0; p < NS; p++) begin : g_pos
    // forward order uses the widest stage first, inverse order the narrowest
    localparam int unsigned   KF = NS - 1 - p;
    localparam int unsigned   KU = p;
    localparam logic [W-1:0]  LF = upper_mask(KF);
    localparam logic [W-1:0]  RF = lower_mask(KF);
    localparam logic [W-1:0]  LU = upper_mask(KU);
    localparam logic [W-1:0]  RU = lower_mask(KU);
    localparam int unsigned   DF = 1 << KF;
    localparam int unsigned   DU = 1 << KU;
    logic [W-1:0] fwd, inv;
    assign fwd = (stg[p] & ~(LF | RF)) | ((stg[p] << DF) & LF) | ((stg[p] >> DF) & RF);
    assign inv = (stg[p] & ~(LU | RU)) | ((stg[p] << DU) & LU) | ((stg[p] >> DU) & RU);
    always_comb begin
      if (unzip) stg[p+1] = amt[KU] ? inv : stg[p];
      else       stg[p+1] = amt[KF] ? fwd : stg[p];
    end
  end

  assign dout = stg[NS];

endmodule

// File: rtl/bperm_unit.sv
module bperm_unit #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_data,
  input  logic [W-1:0] in_ctl,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  import bperm_pkg::*;

  localparam int unsigned LW = $clog2(W);
  localparam int unsigned NS = LW - 1;

  bp_op_e       op;
  logic [W-1:0] swap_res, zip_res, result;
  logic         accept;
  logic         ctl_unused;

  assign op         = bp_op_e'(in_op);
  assign ctl_unused = ^in_ctl[W-1:LW];

  bperm_swap_net #(.W(W), .LW(LW)) u_swap (
    .din   (in_data),
    .amt   (in_ctl[LW-1:0]),
    .merge (op == BP_ORC),
    .dout  (swap_res)
  );

  bperm_zip_net #(.W(W), .LW(LW), .NS(NS)) u_zip (
    .din   (in_data),
    .amt   (in_ctl[NS-1:0]),
    .unzip (op == BP_UNZIP),
    .dout  (zip_res)
  );

  always_comb begin
    case (op)
      BP_REV, BP_ORC: result = swap_res;
      default:        result = zip_res;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/bperm_unit_chk.sv
module bperm_unit_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [1:0]   in_op,
  input logic [W-1:0] in_data,
  input logic [W-1:0] in_ctl,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  localparam int unsigned LW = $clog2(W);

  function automatic logic [W-1:0] flip_bits(logic [W-1:0] x);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = x[W-1-i];
    return r;
  endfunction

  logic take;
  assign take = in_valid && in_ready;

  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);  // R2

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);  // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R3

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);  // R3

  AST_FULL_REVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 2'b00 && in_ctl[LW-1:0] == '1) |=> out_data == flip_bits($past(in_data)));  // R4

  AST_ORC_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 2'b01) |=> ((out_data & $past(in_data)) == $past(in_data)));  // R5

  AST_ZERO_AMOUNT_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_ctl[LW-1:0] == '0) |=> out_data == $past(in_data));  // R9

endmodule

bind bperm_unit bperm_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_data   (in_data),
  .in_ctl    (in_ctl),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/bperm_unit_test.sv
`timescale 1ns/1ps
module bperm_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [63:0] in_data = '0;
  logic [63:0] in_ctl = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def0;

  always #2.5 clk = ~clk;

  bperm_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_data(in_data), .in_ctl(in_ctl),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [63:0] next_rand();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  function automatic logic [63:0] ref_rev(logic [63:0] x, logic [5:0] a);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = x[i ^ int'(a)];
    return r;
  endfunction

  function automatic logic [63:0] ref_orc(logic [63:0] x, logic [5:0] a);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      r[i] = 1'b0;
      for (int j = 0; j < 64; j++)
        if (((i ^ j) & ~int'(a) & 63) == 0) r[i] = r[i] | x[j];
    end
    return r;
  endfunction

  function automatic logic [63:0] zst(logic [63:0] x, logic [63:0] l, logic [63:0] r, int n);
    return (x & ~(l | r)) | ((x << n) & l) | ((x >> n) & r);
  endfunction

  function automatic logic [63:0] ref_zip(logic [63:0] x, logic [4:0] s);
    if (s[4]) x = zst(x, 64'h0000ffff00000000, 64'h00000000ffff0000, 16);
    if (s[3]) x = zst(x, 64'h00ff000000ff0000, 64'h0000ff000000ff00, 8);
    if (s[2]) x = zst(x, 64'h0f000f000f000f00, 64'h00f000f000f000f0, 4);
    if (s[1]) x = zst(x, 64'h3030303030303030, 64'h0c0c0c0c0c0c0c0c, 2);
    if (s[0]) x = zst(x, 64'h4444444444444444, 64'h2222222222222222, 1);
    return x;
  endfunction

  function automatic logic [63:0] ref_unzip(logic [63:0] x, logic [4:0] s);
    if (s[0]) x = zst(x, 64'h4444444444444444, 64'h2222222222222222, 1);
    if (s[1]) x = zst(x, 64'h3030303030303030, 64'h0c0c0c0c0c0c0c0c, 2);
    if (s[2]) x = zst(x, 64'h0f000f000f000f00, 64'h00f000f000f000f0, 4);
    if (s[3]) x = zst(x, 64'h00ff000000ff0000, 64'h0000ff000000ff00, 8);
    if (s[4]) x = zst(x, 64'h0000ffff00000000, 64'h00000000ffff0000, 16);
    return x;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one transfer with the output free; result read one edge later
  task automatic xfer(logic [1:0] op, logic [63:0] d, logic [63:0] c, string req,
                      output logic [63:0] res);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_op     = op;
    in_data   = d;
    in_ctl    = c;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " out_valid"}, {63'd0, out_valid}, 64'd1);
    res = out_data;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 out_data", out_data, 64'd0);
    chk("R1 in_ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_reverse();
    logic [63:0] r, d;
    d = 64'h0123_4567_89ab_cdef;
    xfer(2'b00, d, 64'd63, "R4", r);
    chk("R4 full reverse", r, {<<{d}});
    xfer(2'b00, d, 64'd56, "R4", r);
    chk("R4 byte reverse", r, 64'hefcd_ab89_6745_2301);
    for (int n = 0; n < 6; n++) begin
      d = next_rand();
      xfer(2'b00, d, 64'(n * 11 + 5) & 64'h3f, "R4", r);
      chk("R4 pattern", r, ref_rev(d, 6'(n * 11 + 5)));
    end
  endtask

  task automatic t_orc();
    logic [63:0] r, d;
    d = 64'h0000_1000_0000_0001;
    xfer(2'b01, d, 64'd7, "R5", r);
    chk("R5 byte any-set", r, 64'h0000_ff00_0000_00ff);
    for (int n = 0; n < 5; n++) begin
      d = next_rand() & next_rand() & next_rand();
      xfer(2'b01, d, 64'(n * 13 + 3) & 64'h3f, "R5", r);
      chk("R5 pattern", r, ref_orc(d, 6'(n * 13 + 3)));
    end
  endtask

  task automatic t_zip();
    logic [63:0] r, d, e;
    d = next_rand();
    for (int i = 0; i < 32; i++) begin
      e[2*i]   = d[i];
      e[2*i+1] = d[i+32];
    end
    xfer(2'b10, d, 64'd31, "R6", r);
    chk("R6 full zip", r, e);
    for (int n = 0; n < 6; n++) begin
      d = next_rand();
      xfer(2'b10, d, 64'(n * 7 + 1) & 64'h1f, "R6", r);
      chk("R6 pattern", r, ref_zip(d, 5'(n * 7 + 1)));
    end
  endtask

  task automatic t_unzip();
    logic [63:0] r, z, d;
    for (int n = 0; n < 5; n++) begin
      d = next_rand();
      xfer(2'b10, d, 64'(n * 9 + 4) & 64'h1f, "R7", z);
      xfer(2'b11, z, 64'(n * 9 + 4) & 64'h1f, "R7", r);
      chk("R7 round trip", r, d);
      xfer(2'b11, d, 64'(n * 9 + 4) & 64'h1f, "R7", r);
      chk("R7 stage order", r, ref_unzip(d, 5'(n * 9 + 4)));
    end
  endtask

  task automatic t_upper_ignored();
    logic [63:0] r, d;
    d = next_rand();
    xfer(2'b00, d, 64'hffff_ffff_ffff_ffc5, "R8", r);
    chk("R8 reverse upper", r, ref_rev(d, 6'h05));
    xfer(2'b01, d & 64'h0101_0000_0000_8001, 64'hdead_beef_0000_0042, "R8", r);
    chk("R8 orc upper", r, ref_orc(d & 64'h0101_0000_0000_8001, 6'h02));
    xfer(2'b10, d, 64'hffff_ffff_ffff_ffe3, "R8", r);
    chk("R8 zip upper", r, ref_zip(d, 5'h03));
    xfer(2'b11, d, 64'h8000_0000_0000_0020, "R8", r);
    chk("R8 unzip bit5 ignored", r, d);
  endtask

  task automatic t_zero_amount();
    logic [63:0] r, d;
    for (int op = 0; op < 4; op++) begin
      d = next_rand();
      xfer(2'(op), d, 64'd0, "R9", r);
      chk("R9 identity", r, d);
    end
  endtask

  task automatic t_stall();
    logic [63:0] a, b;
    a = next_rand();
    b = next_rand();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'b00; in_data = a; in_ctl = 64'd0;
    @(negedge clk);
    chk("R2 stall valid", {63'd0, out_valid}, 64'd1);
    chk("R3 in_ready low", {63'd0, in_ready}, 64'd0);
    in_data = b; in_ctl = 64'd63;
    @(negedge clk);
    chk("R3 held data", out_data, a);
    chk("R3 held valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R3 held data again", out_data, a);
    out_ready = 1'b1;
    #0.5;
    chk("R3 ready returns", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 next result", out_data, {<<{b}});
    chk("R2 next valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R2 drained", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_stream();
    logic [63:0] d [0:3];
    for (int n = 0; n < 4; n++) d[n] = next_rand();
    out_ready = 1'b1;
    for (int n = 0; n <= 4; n++) begin
      @(negedge clk);
      if (n > 0) begin
        chk("R2 stream valid", {63'd0, out_valid}, 64'd1);
        chk("R2 stream data", out_data, ref_rev(d[n-1], 6'(n + 1)));
      end
      if (n < 4) begin
        in_valid = 1'b1; in_op = 2'b00; in_data = d[n]; in_ctl = 64'(n + 2);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R2 stream end", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    #20;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reverse();
    t_orc();
    t_zip();
    t_unzip();
    t_upper_ignored();
    t_zero_amount();
    t_stall();
    t_stream();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule